// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a small set of one-bit hardware semaphores that two independent ports, called left and right, use to claim and hand over shared resources. Each port has its own select, memory-enable, write, output-enable, address and data signals. A port reaches the bank only when its semaphore select is high and its memory enable is low. The low address bits pick a semaphore.

Each semaphore shows each port that port's own view. A port reads zero when it holds the semaphore and one when it does not. To claim a semaphore, a port writes zero. To give it up, the port writes one. If the other port writes zero while the semaphore is held, that port waits. It then takes ownership in the same cycle as the release, so the semaphore never passes through the free state. When both ports request a free semaphore in the same cycle, the left port wins and the right port waits.

Reads are captured in a per-port output register. A later write from the other side cannot disturb a value that has already been returned. A port checks a request by reading the semaphore in a later cycle.

Top module: `sem_bank_dp`

## Requirements
- R1: After a synchronous reset every semaphore is free and both read-data outputs show all ones.
- R2: A port's cycle counts as a semaphore access only when its select is high and its memory enable is low. Otherwise its write changes no semaphore and its read-data output keeps its value.
- R3: The semaphore index is address bits [2:0]. Higher address bits have no effect.
- R4: A write with data bit 0 equal to 0 to a free semaphore gives that port ownership. Data bits above bit 0 are ignored. The owner then reads 0 on every data bit, and the other port reads 1 on every data bit.
- R5: A non-owner writing 0 to a held semaphore leaves the owner unchanged and records a pending request. A non-owner writing 1 leaves the owner unchanged and cancels its pending request.
- R6: When the owner writes 1 and no request is pending, the semaphore becomes free and both ports read 1.
- R7: When the owner writes 1 while the other port has a pending request, or while the other port writes 0 in the same cycle, the other port owns the semaphore from the next cycle on.
- R8: When both ports write 0 to a free semaphore in the same cycle, the left port gets ownership and the right port's request becomes pending.
- R9: A read (access with write low and output enable high) loads the port's read-data register one cycle later with the view before that cycle's writes. The register holds its value until that port's next read.
- R10: Each of the eight semaphores changes only through accesses to its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; must be low for semaphore access |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 12 | Left address; bits [2:0] pick the semaphore |
| l_wdata | input | 16 | Left write data; only bit 0 is used |
| l_rdata | output | 16 | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; must be low for semaphore access |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 12 | Right address; bits [2:0] pick the semaphore |
| r_wdata | input | 16 | Right write data; only bit 0 is used |
| r_rdata | output | 16 | Right registered read data |

## Verification
A wrong owner or pending flag does not show at the ports on its own. It shows only one cycle after a port reads that index: the read-data word has the wrong polarity on every bit. A lost pending request shows as the waiting port still reading ones after the owner's release. A stray write to the wrong index shows on the first read of the disturbed semaphore. The bench therefore interleaves reads densely with writes, so that each corrupted state is seen within a few cycles.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;

  typedef struct packed {
    logic       hit;
    logic       wr;
    logic       rd;
    logic       bit0;
  } sem_cmd_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               mem_en,
  input  logic               we,
  input  logic               oe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_en,
  output logic [IDX_W-1:0]   idx
);
  import sem_bank_pkg::*;

  sem_cmd_t cmd;

  always_comb begin
    cmd.hit  = sel & ~mem_en;
    cmd.wr   = cmd.hit & we;
    cmd.rd   = cmd.hit & ~we & oe;
    cmd.bit0 = wdata[0];
  end

  assign idx   = addr[IDX_W-1:0];
  assign rd_en = cmd.rd;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sel
    assign req_vec[g] = cmd.wr & ~cmd.bit0 & (idx == IDX_W'(g));
    assign rel_vec[g] = cmd.wr &  cmd.bit0 & (idx == IDX_W'(g));
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_vec | rel_vec)); // R10
  AST_GATED_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (!sel || mem_en) |-> ((req_vec | rel_vec) == '0 && !rd_en)); // R2
endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_view,
  output logic r_view
);
  import sem_bank_pkg::*;

  sem_owner_e owner, owner_nx;
  logic       waiting, waiting_nx;

  always_comb begin
    owner_nx   = owner;
    waiting_nx = waiting;
    unique case (owner)
      OWN_NONE: begin
        waiting_nx = 1'b0;
        if (l_req) begin
          owner_nx   = OWN_LEFT;
          waiting_nx = r_req;
        end else if (r_req) begin
          owner_nx   = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (l_rel) begin
          owner_nx   = ((waiting & ~r_rel) | r_req) ? OWN_RIGHT : OWN_NONE;
          waiting_nx = 1'b0;
        end else if (r_req) begin
          waiting_nx = 1'b1;
        end else if (r_rel) begin
          waiting_nx = 1'b0;
        end
      end
      OWN_RIGHT: begin
        if (r_rel) begin
          owner_nx   = ((waiting & ~l_rel) | l_req) ? OWN_LEFT : OWN_NONE;
          waiting_nx = 1'b0;
        end else if (l_req) begin
          waiting_nx = 1'b1;
        end else if (l_rel) begin
          waiting_nx = 1'b0;
        end
      end
      default: begin
        owner_nx   = OWN_NONE;
        waiting_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner   <= OWN_NONE;
      waiting <= 1'b0;
    end else begin
      owner   <= owner_nx;
      waiting <= waiting_nx;
    end
  end

  assign l_view = (owner != OWN_LEFT);
  assign r_view = (owner != OWN_RIGHT);

  AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_NONE && l_req && r_req) |=> (owner == OWN_LEFT && waiting)); // R8
  AST_HANDOFF_L2R: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && waiting && l_rel && !r_rel) |=> (owner == OWN_RIGHT)); // R7
  AST_HANDOFF_R2L: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_RIGHT && waiting && r_rel && !l_rel) |=> (owner == OWN_LEFT)); // R7
  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !waiting && l_rel && !r_req) |=> (owner == OWN_NONE)); // R6
  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !l_rel) |=> (owner == OWN_LEFT)); // R5
  AST_WAIT_NEEDS_OWNER: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (owner != OWN_NONE)); // R5
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              view,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{view}};
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R9
  AST_RD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (rdata == '0) || (rdata == '1)); // R4
endmodule

// File: rtl/sem_bank_dp.sv
module sem_bank_dp #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int NUM_SEM = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] l_view, r_view;
  logic               l_rd, r_rd;
  logic [IDX_W-1:0]   l_idx, r_idx;

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
    .clk(clk), .rst(rst), .sel(l_sel), .mem_en(l_mem_en), .we(l_we), .oe(l_oe),
    .addr(l_addr), .wdata(l_wdata), .req_vec(l_req), .rel_vec(l_rel),
    .rd_en(l_rd), .idx(l_idx));

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
    .clk(clk), .rst(rst), .sel(r_sel), .mem_en(r_mem_en), .we(r_we), .oe(r_oe),
    .addr(r_addr), .wdata(r_wdata), .req_vec(r_req), .rel_vec(r_rel),
    .rd_en(r_rd), .idx(r_idx));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_req[g]), .l_rel(l_rel[g]),
      .r_req(r_req[g]), .r_rel(r_rel[g]),
      .l_view(l_view[g]), .r_view(r_view[g]));
  end

  sem_read_reg #(.DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .view(l_view[l_idx]), .rdata(l_rdata));

  sem_read_reg #(.DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .view(r_view[r_idx]), .rdata(r_rdata));

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (l_rdata == '1 && r_rdata == '1)); // R1
endmodule

// File: tb/tb_sem_bank_dp.sv
module tb_sem_bank_dp;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          l_sel, l_men, l_we, l_oe, r_sel, r_men, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd;
  logic [DW-1:0] l_rd, r_rd;

  sem_bank_dp #(.ADDR_W(AW), .DATA_W(DW), .NUM_SEM(NS)) dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_men), .l_we(l_we), .l_oe(l_oe),
    .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd),
    .r_sel(r_sel), .r_mem_en(r_men), .r_we(r_we), .r_oe(r_oe),
    .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd));

  int checks = 0;
  int fails  = 0;
  int own  [NS];   // 0 free, 1 left, 2 right
  bit pend [NS];
  logic [DW-1:0] exp_l, exp_r;

  function automatic bit view_of(int o, int side);
    return (o != side);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {l_sel, l_men, l_we, l_oe, r_sel, r_men, r_we, r_oe} = '0;
    l_addr = '0; r_addr = '0; l_wd = '0; r_wd = '0;
  endtask

  task automatic lw(int a, logic [DW-1:0] d);
    l_sel = 1; l_men = 0; l_we = 1; l_oe = 0; l_addr = AW'(a); l_wd = d;
  endtask
  task automatic rw(int a, logic [DW-1:0] d);
    r_sel = 1; r_men = 0; r_we = 1; r_oe = 0; r_addr = AW'(a); r_wd = d;
  endtask
  task automatic lr(int a);
    l_sel = 1; l_men = 0; l_we = 0; l_oe = 1; l_addr = AW'(a);
  endtask
  task automatic rr(int a);
    r_sel = 1; r_men = 0; r_we = 0; r_oe = 1; r_addr = AW'(a);
  endtask

  // Reference model of one clock edge, built from the requirements.
  task automatic model_edge();
    bit lh = l_sel && !l_men;
    bit rh = r_sel && !r_men;
    int li = int'(l_addr[2:0]);
    int ri = int'(r_addr[2:0]);
    if (lh && !l_we && l_oe) exp_l = {DW{view_of(own[li], 1)}};
    if (rh && !r_we && r_oe) exp_r = {DW{view_of(own[ri], 2)}};
    for (int k = 0; k < NS; k++) begin
      bit lq = lh && l_we && li == k && !l_wd[0];
      bit ls = lh && l_we && li == k &&  l_wd[0];
      bit rq = rh && r_we && ri == k && !r_wd[0];
      bit rs = rh && r_we && ri == k &&  r_wd[0];
      case (own[k])
        0: begin
          pend[k] = 0;
          if (lq) begin own[k] = 1; pend[k] = rq; end
          else if (rq) own[k] = 2;
        end
        1: begin
          if (ls) begin own[k] = ((pend[k] && !rs) || rq) ? 2 : 0; pend[k] = 0; end
          else if (rq) pend[k] = 1;
          else if (rs) pend[k] = 0;
        end
        default: begin
          if (rs) begin own[k] = ((pend[k] && !ls) || lq) ? 1 : 0; pend[k] = 0; end
          else if (lq) pend[k] = 1;
          else if (ls) pend[k] = 0;
        end
      endcase
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " left"},  l_rd, exp_l);
    check({tag, " right"}, r_rd, exp_r);
    idle();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    for (int k = 0; k < NS; k++) begin own[k] = 0; pend[k] = 0; end
    exp_l = '1; exp_r = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset left", l_rd, '1);
    check("R1 reset right", r_rd, '1);
    lr(5); rr(5); step("R1 read free");

    // R3/R4: request via high address bits, data bits above 0 ignored
    lw(12'hAB3, 16'hFFFE); step("R4 request");
    lr(12'h003); rr(12'hF0B); step("R3 R4 views");
    check("R4 owner zero", l_rd, 16'h0000);
    check("R4 other one", r_rd, 16'hFFFF);

    // R2: gated accesses
    rw(6, 16'h0000); r_men = 1; step("R2 mem_en write");
    rr(6); step("R2 still free");
    lr(3); l_sel = 0; step("R2 read ignored");
    check("R2 hold", l_rd, 16'h0000);

    // R5/R7: pending then handoff
    rw(3, 16'h0); step("R5 pend");
    rr(3); lr(3); step("R5 still left");
    lw(3, 16'h1); step("R7 release");
    rr(3); lr(3); step("R7 right owns");
    check("R7 right zero", r_rd, 16'h0000);

    // R5 cancel, R6 free
    lw(3, 16'h0); step("R5 left pend");
    lw(3, 16'h1); step("R5 cancel");
    rw(3, 16'h1); step("R6 release");
    lr(3); rr(3); step("R6 free");
    check("R6 both one", l_rd & r_rd, 16'hFFFF);

    // R8 tie
    lw(2, 16'h0); rw(2, 16'h0); step("R8 tie");
    lr(2); rr(2); step("R8 left wins");
    lw(2, 16'h1); step("R8 pend handoff");
    rr(2); step("R8 right owns");

    // R9: read captures pre-write view; R10 neighbour untouched
    lw(1, 16'h0); rr(1); step("R9 pre-write view");
    rr(0); step("R10 neighbour");
    idle(); step("R9 hold");

    for (int n = 0; n < 4000; n++) begin
      int lo = $urandom_range(0, 2);
      int ro = $urandom_range(0, 2);
      if (lo == 1) lw($urandom_range(0, 4095), DW'($urandom));
      else if (lo == 2) lr($urandom_range(0, 4095));
      if (ro == 1) rw($urandom_range(0, 4095), DW'($urandom));
      else if (ro == 2) rr($urandom_range(0, 4095));
      if ($urandom_range(0, 7) == 0) l_men = 1;
      if ($urandom_range(0, 7) == 0) r_sel = 0;
      if ($urandom_range(0, 5) == 0) l_oe = 0;
      step("R5 R7 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule